// File: doc/BRIEF.md
# Single-Level Page Table Walker

This unit turns a virtual address into a physical address by fetching one page table entry from memory. A requester presents a virtual address and an access kind (load or store) with a valid/ready handshake. The table base is taken from the `ptbr` input at the moment the request is accepted. The unit adds the virtual page number, scaled by the entry size, to that base. It issues one read on its memory port and waits for the entry to return, however many cycles that takes.

The returned entry is decoded into a present bit, read and write permissions and a frame field. The unit then produces exactly one response. A good translation carries the physical address, made of the frame number followed by the untouched page offset. Otherwise the response carries one of two fault flags. A page fault means the page is absent or its frame lies outside physical memory. A protection fault means the page is present but the access kind is not allowed. Only one request is in flight at a time: the unit steps from idle, to issuing the read, to waiting for data, to responding, and then back to idle.

With the defaults the virtual address is 14 bits, the physical address is 12 bits, pages are 64 bytes and each entry is 2 bytes.

Top module: `pt_xlate_unit`

## Requirements
- R1: Out of reset `req_ready` is 1, and `mem_rd_en` and `rsp_valid` are 0.
- R2: A request is taken only on a cycle with `req_valid` and `req_ready` both high. `req_ready` stays low from acceptance until the cycle after the response, so a request held high during that time is taken only once.
- R3: In the cycle after acceptance `mem_rd_en` is high for exactly one cycle. `mem_addr` is then (ptbr + VPN*2) mod 4096, where VPN is virtual address bits [13:6]. The sum wraps at the top of the physical space.
- R4: Read data is consumed only while the unit waits for an entry. In any other state a `mem_rd_valid` pulse has no effect. `rsp_valid` is a one-cycle pulse in the cycle after the consumed `mem_rd_valid`.
- R5: Entry layout: bit 15 is present, bit 14 allows loads, bit 13 allows stores, and bits [12:0] hold the frame number. A frame number of 64 or more cannot be addressed and is reported as a page fault.
- R6: For a present, permitted, in-range entry, `rsp_pa` is {frame[5:0], va[5:0]}. The offset bits are carried through unchanged. Example: va 0x03D4 with entry frame 0x0D gives 0x354.
- R7: An entry with bit 15 clear gives `rsp_page_fault`=1, `rsp_prot_fault`=0 and `rsp_pa`=0, whatever its permission bits are.
- R8: A present entry accessed by a load without bit 14, or by a store without bit 13, gives `rsp_prot_fault`=1, `rsp_page_fault`=0 and `rsp_pa`=0.
- R9: Changes to `req_va`, `req_write` or `ptbr` after acceptance do not alter the read address or the response of that request.
- R10: Each accepted request produces exactly one memory read and exactly one response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ptbr | input | 12 | Byte address of the page table, sampled at acceptance |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_va | input | 14 | Virtual address to translate |
| req_write | input | 1 | 1 = store access, 0 = load access |
| mem_rd_en | output | 1 | One-cycle read strobe for the entry |
| mem_addr | output | 12 | Byte address of the entry |
| mem_rd_valid | input | 1 | Entry data valid |
| mem_rd_data | input | 16 | Entry contents |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_pa | output | 12 | Physical address, 0 on a fault |
| rsp_page_fault | output | 1 | Page absent or frame out of range |
| rsp_prot_fault | output | 1 | Access kind not permitted |

## Verification
Several properties are checked on every cycle: the read and response strobes last one cycle each, a read follows only an accepted handshake, a response follows only consumed read data, the two fault flags never appear together, a faulting response carries a zero address, and the unit is never ready while a response is out. Other behaviour can only be shown by the bench's scenarios. These are the actual address values, the entry address arithmetic including wraparound, the frame range check, immunity to inputs changed mid-flight, and the discarding of stray read data while idle.

// File: rtl/pt_xlate_pkg.sv
package pt_xlate_pkg;

  // Walker sequence: accept -> strobe read -> wait for entry -> respond
  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_ISSUE = 2'd1,
    XS_WAIT  = 2'd2,
    XS_RESP  = 2'd3
  } xlate_state_e;

  typedef struct packed {
    logic page_fault;
    logic prot_fault;
  } xlate_fault_t;

endpackage

// File: rtl/pte_addr_gen.sv
module pte_addr_gen #(
  parameter int BASE_W    = 12,
  parameter int VPN_W     = 8,
  parameter int PTE_BYTES = 2
) (
  input  logic [BASE_W-1:0] base,
  input  logic [VPN_W-1:0]  vpn,
  output logic [BASE_W-1:0] entry_addr
);

  // Entry size is a power of two, so scaling is a shift
  localparam int SHIFT = $clog2(PTE_BYTES);

  logic [BASE_W-1:0] scaled;

  generate
    if (SHIFT == 0) begin : g_unit
      assign scaled = BASE_W'(vpn);
    end else begin : g_shift
      assign scaled = BASE_W'({vpn, {SHIFT{1'b0}}});
    end
  endgenerate

  // Modulo-2^BASE_W sum: the table may wrap past the top of memory
  assign entry_addr = base + scaled;

endmodule

// File: rtl/pte_checker.sv
module pte_checker
  import pt_xlate_pkg::*;
#(
  parameter int PTE_W  = 16,
  parameter int PPN_W  = 6,
  parameter int OFF_W  = 6,
  parameter int PA_W   = PPN_W + OFF_W
) (
  input  logic [PTE_W-1:0] pte,
  input  logic             is_write,
  input  logic [OFF_W-1:0] offset,
  output logic [PA_W-1:0]  pa,
  output xlate_fault_t     fault
);

  // Flags sit in the top three bits; the rest is the frame field
  localparam int P_BIT   = PTE_W - 1;
  localparam int R_BIT   = PTE_W - 2;
  localparam int W_BIT   = PTE_W - 3;
  localparam int FRAME_W = PTE_W - 3;

  logic [FRAME_W-1:0] frame;
  logic               in_range;
  logic               present;
  logic               allowed;

  assign frame = pte[FRAME_W-1:0];

  generate
    if (FRAME_W > PPN_W) begin : g_range
      assign in_range = (frame[FRAME_W-1:PPN_W] == '0);
    end else begin : g_fit
      assign in_range = 1'b1;
    end
  endgenerate

  assign present = pte[P_BIT] && in_range;
  assign allowed = is_write ? pte[W_BIT] : pte[R_BIT];

  always_comb begin
    fault.page_fault = !present;
    fault.prot_fault = present && !allowed;
    if (present && allowed) begin
      pa = {frame[PPN_W-1:0], offset};
    end else begin
      pa = '0;
    end
  end

endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import pt_xlate_pkg::*;
#(
  parameter int VA_W  = 14,
  parameter int OFF_W = 6,
  parameter int PA_W  = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_va,
  input  logic             req_write,
  input  logic [PA_W-1:0]  entry_addr,
  output logic             mem_rd_en,
  output logic [PA_W-1:0]  mem_addr,
  input  logic             mem_rd_valid,
  output logic [OFF_W-1:0] off_q,
  output logic             write_q,
  input  logic [PA_W-1:0]  chk_pa,
  input  xlate_fault_t     chk_fault,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_pa,
  output logic             rsp_page_fault,
  output logic             rsp_prot_fault
);

  xlate_state_e state_q;

  assign req_ready = (state_q == XS_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q        <= XS_IDLE;
      mem_rd_en      <= 1'b0;
      mem_addr       <= '0;
      off_q          <= '0;
      write_q        <= 1'b0;
      rsp_valid      <= 1'b0;
      rsp_pa         <= '0;
      rsp_page_fault <= 1'b0;
      rsp_prot_fault <= 1'b0;
    end else begin
      mem_rd_en <= 1'b0;
      rsp_valid <= 1'b0;
      unique case (state_q)
        XS_IDLE: begin
          if (req_valid) begin
            off_q     <= req_va[OFF_W-1:0];
            write_q   <= req_write;
            mem_addr  <= entry_addr;
            mem_rd_en <= 1'b1;
            state_q   <= XS_ISSUE;
          end
        end
        XS_ISSUE: state_q <= XS_WAIT;
        XS_WAIT: begin
          if (mem_rd_valid) begin
            rsp_valid      <= 1'b1;
            rsp_pa         <= chk_pa;
            rsp_page_fault <= chk_fault.page_fault;
            rsp_prot_fault <= chk_fault.prot_fault;
            state_q        <= XS_RESP;
          end
        end
        default: state_q <= XS_IDLE;
      endcase
    end
  end

  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en); // R3
  AST_RD_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_rd_en) |-> $past(req_valid && req_ready)); // R2
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R4
  AST_RSP_AFTER_DATA: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(mem_rd_valid)); // R4
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid || mem_rd_en) |-> !req_ready); // R2
  AST_FAULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !(rsp_page_fault && rsp_prot_fault)); // R7
  AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && (rsp_page_fault || rsp_prot_fault)) |-> (rsp_pa == '0)); // R8
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_page_fault && !rsp_prot_fault) |-> (rsp_pa[OFF_W-1:0] == off_q)); // R6

endmodule

// File: rtl/pt_xlate_unit.sv
module pt_xlate_unit
  import pt_xlate_pkg::*;
#(
  parameter int VA_W      = 14,
  parameter int PA_W      = 12,
  parameter int OFF_W     = 6,
  parameter int PTE_BYTES = 2,
  localparam int VPN_W    = VA_W - OFF_W,
  localparam int PPN_W    = PA_W - OFF_W,
  localparam int PTE_W    = 8 * PTE_BYTES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PA_W-1:0]  ptbr,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_va,
  input  logic             req_write,
  output logic             mem_rd_en,
  output logic [PA_W-1:0]  mem_addr,
  input  logic             mem_rd_valid,
  input  logic [PTE_W-1:0] mem_rd_data,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_pa,
  output logic             rsp_page_fault,
  output logic             rsp_prot_fault
);

  logic [PA_W-1:0]  entry_addr;
  logic [OFF_W-1:0] off_q;
  logic             write_q;
  logic [PA_W-1:0]  chk_pa;
  xlate_fault_t     chk_fault;

  pte_addr_gen #(
    .BASE_W    (PA_W),
    .VPN_W     (VPN_W),
    .PTE_BYTES (PTE_BYTES)
  ) u_addr (
    .base       (ptbr),
    .vpn        (req_va[VA_W-1:OFF_W]),
    .entry_addr (entry_addr)
  );

  pte_checker #(
    .PTE_W (PTE_W),
    .PPN_W (PPN_W),
    .OFF_W (OFF_W),
    .PA_W  (PA_W)
  ) u_check (
    .pte      (mem_rd_data),
    .is_write (write_q),
    .offset   (off_q),
    .pa       (chk_pa),
    .fault    (chk_fault)
  );

  xlate_ctrl #(
    .VA_W  (VA_W),
    .OFF_W (OFF_W),
    .PA_W  (PA_W)
  ) u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_va         (req_va),
    .req_write      (req_write),
    .entry_addr     (entry_addr),
    .mem_rd_en      (mem_rd_en),
    .mem_addr       (mem_addr),
    .mem_rd_valid   (mem_rd_valid),
    .off_q          (off_q),
    .write_q        (write_q),
    .chk_pa         (chk_pa),
    .chk_fault      (chk_fault),
    .rsp_valid      (rsp_valid),
    .rsp_pa         (rsp_pa),
    .rsp_page_fault (rsp_page_fault),
    .rsp_prot_fault (rsp_prot_fault)
  );

endmodule

// File: tb/pt_xlate_unit_bench.sv
module pt_xlate_unit_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] ptbr = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [13:0] req_va = '0;
  logic        req_write = 1'b0;
  logic        mem_rd_en;
  logic [11:0] mem_addr;
  logic        mem_valid_q = 1'b0;
  logic        stray = 1'b0;
  logic        mem_rd_valid;
  logic [15:0] mem_rd_data = '0;
  logic        rsp_valid;
  logic [11:0] rsp_pa;
  logic        rsp_page_fault;
  logic        rsp_prot_fault;

  int n_checks = 0;
  int n_fail   = 0;
  int rd_count = 0;
  int rsp_count = 0;
  int cycles   = 0;
  int lat_cfg  = 0;
  logic        pend = 1'b0;
  int          pend_cnt = 0;
  logic [11:0] pend_addr = '0;
  logic [15:0] mem [0:2047];

  always #5 clk = ~clk;

  assign mem_rd_valid = mem_valid_q | stray;

  pt_xlate_unit u_pt_xlate_unit (
    .clk (clk), .rst (rst), .ptbr (ptbr),
    .req_valid (req_valid), .req_ready (req_ready),
    .req_va (req_va), .req_write (req_write),
    .mem_rd_en (mem_rd_en), .mem_addr (mem_addr),
    .mem_rd_valid (mem_rd_valid), .mem_rd_data (mem_rd_data),
    .rsp_valid (rsp_valid), .rsp_pa (rsp_pa),
    .rsp_page_fault (rsp_page_fault), .rsp_prot_fault (rsp_prot_fault)
  );

  // Table memory with configurable latency
  always @(posedge clk) begin
    cycles <= cycles + 1;
    mem_valid_q <= 1'b0;
    if (mem_rd_en) begin
      rd_count  <= rd_count + 1;
      pend      <= 1'b1;
      pend_cnt  <= lat_cfg;
      pend_addr <= mem_addr;
    end else if (pend) begin
      if (pend_cnt == 0) begin
        mem_valid_q <= 1'b1;
        mem_rd_data <= mem[pend_addr[11:1]];
        pend <= 1'b0;
      end else begin
        pend_cnt <= pend_cnt - 1;
      end
    end
    if (rsp_valid) rsp_count <= rsp_count + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    while (cycles < 20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    finish_run();
  end

  typedef struct packed {
    logic [11:0] base;
    logic [13:0] va;
    logic        wr;
    logic [15:0] pte;
    logic [11:0] pa;
    logic        pf;
    logic        prf;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [0:NV-1] = '{
    '{12'h100, 14'h03D4, 1'b0, 16'hC00D, 12'h354, 1'b0, 1'b0}, // R6 worked example
    '{12'h200, 14'h0005, 1'b1, 16'hE028, 12'hA05, 1'b0, 1'b0}, // R6 store, vpn 0
    '{12'h400, 14'h3FFF, 1'b0, 16'hC03F, 12'hFFF, 1'b0, 1'b0}, // R6 top page
    '{12'h300, 14'h0040, 1'b0, 16'h600D, 12'h000, 1'b1, 1'b0}, // R7 absent, perms set
    '{12'h300, 14'h0380, 1'b1, 16'hC011, 12'h000, 1'b0, 1'b1}, // R8 store, no write
    '{12'h300, 14'h0380, 1'b0, 16'hA011, 12'h000, 1'b0, 1'b1}, // R8 load, no read
    '{12'h300, 14'h0100, 1'b1, 16'h0000, 12'h000, 1'b1, 1'b0}, // R7 absent wins
    '{12'hFFE, 14'h00A7, 1'b0, 16'hC02D, 12'hB67, 1'b0, 1'b0}, // R3 wrap
    '{12'h500, 14'h0123, 1'b0, 16'hC045, 12'h000, 1'b1, 1'b0}, // R5 frame too large
    '{12'h600, 14'h2A9C, 1'b1, 16'hE03A, 12'hE9C, 1'b0, 1'b0}  // R6 store
  };

  task automatic run_vec(input vec_t v, input int lat);
    logic [11:0] eaddr;
    int rd0;
    int rs0;
    bit got;
    eaddr = v.base + {3'b000, v.va[13:6], 1'b0};
    mem[eaddr[11:1]] = v.pte;
    lat_cfg = lat;
    rd0 = rd_count;
    rs0 = rsp_count;
    @(negedge clk);
    ptbr = v.base; req_va = v.va; req_write = v.wr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    ptbr = ~v.base; req_va = ~v.va; req_write = ~v.wr; // R9 scramble
    chk("R3 read strobe", {31'd0, mem_rd_en}, 32'd1);
    chk("R3 entry address", {20'd0, mem_addr}, {20'd0, eaddr});
    chk("R2 not ready while busy", {31'd0, req_ready}, 32'd0);
    got = 1'b0;
    for (int k = 0; k < 40 && !got; k++) begin
      @(negedge clk);
      if (rsp_valid) got = 1'b1;
    end
    chk("R4 response seen", {31'd0, got}, 32'd1);
    chk("R6 R9 physical address", {20'd0, rsp_pa}, {20'd0, v.pa});
    chk("R7 R5 page fault", {31'd0, rsp_page_fault}, {31'd0, v.pf});
    chk("R8 protection fault", {31'd0, rsp_prot_fault}, {31'd0, v.prf});
    @(negedge clk);
    chk("R4 response pulse ends", {31'd0, rsp_valid}, 32'd0);
    chk("R10 one read", rd_count - rd0, 32'd1);
    chk("R10 one response", rsp_count - rs0, 32'd1);
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 ready", {31'd0, req_ready}, 32'd1);
    chk("R1 read strobe", {31'd0, mem_rd_en}, 32'd0);
    chk("R1 response", {31'd0, rsp_valid}, 32'd0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i % 3);

    // R2 R10: request held high through a whole transaction is taken once
    begin
      int rd0;
      int rs0;
      bit got;
      mem[(12'h700 + 12'h008) >> 1] = 16'hC00A;
      lat_cfg = 2;
      rd0 = rd_count;
      rs0 = rsp_count;
      @(negedge clk);
      ptbr = 12'h700; req_va = 14'h0111; req_write = 1'b0; req_valid = 1'b1;
      got = 1'b0;
      for (int k = 0; k < 40 && !got; k++) begin
        @(negedge clk);
        if (rsp_valid) got = 1'b1;
      end
      chk("R2 ready low at response", {31'd0, req_ready}, 32'd0);
      req_valid = 1'b0;
      chk("R6 held request address", {20'd0, rsp_pa}, 32'h291);
      repeat (6) @(negedge clk);
      chk("R2 held request single read", rd_count - rd0, 32'd1);
      chk("R10 held request single response", rsp_count - rs0, 32'd1);
    end

    // R4 stray read data while idle is ignored
    begin
      int rs0;
      rs0 = rsp_count;
      @(negedge clk);
      stray = 1'b1;
      @(negedge clk);
      stray = 1'b0;
      repeat (3) @(negedge clk);
      chk("R4 stray data no response", rsp_count - rs0, 32'd0);
      chk("R4 still ready after stray", {31'd0, req_ready}, 32'd1);
    end

    // R1 reset mid-flight returns to idle
    begin
      @(negedge clk);
      ptbr = 12'h100; req_va = 14'h03D4; req_write = 1'b0; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk("R1 ready after reset", {31'd0, req_ready}, 32'd1);
      chk("R1 no response after reset", {31'd0, rsp_valid}, 32'd0);
      repeat (4) @(negedge clk);
    end

    finish_run();
  end

endmodule